// File: doc/BRIEF.md
# Iterative-Capable Microengine Execution Unit

This unit is the arithmetic core of a microcoded engine that interprets bytecodes. A sequencer presents two 32-bit operands and a 5-bit operation code together with a one-cycle start strobe. The unit returns a 32-bit result, a single condition bit and a done pulse. The 32 codes form four groups of eight: moves and add/subtract, two-input bitwise functions including complemented forms, shifts and rotate together with multiply and divide, and comparisons that yield the condition bit.

Most operations finish one clock after start. Signed and unsigned multiply and divide use a shift-and-add or restoring loop that retires one bit per clock, so done arrives later. While such a loop runs, the unit ignores further start strobes. Result and condition hold their values from one completed operation to the next. Operands are captured on the start edge, so the sequencer may change them afterwards.

Top module: `ue_alu`

## Requirements
- R1: While rst_n is low, and after rst_n is released with no start, done_o, cond_o and result_o are all zero.
- R2: Code 0 passes A, code 1 gives A+1, code 2 gives NOT A, code 3 gives the two's complement of A, code 4 gives A+B and code 7 gives A-B, all modulo 2^32. cond_o is 0 for these codes.
- R3: Codes 5 and 6 give result 0 and cond_o 0, whatever the operands and whatever the previous condition.
- R4: Code 8 gives A OR B, 9 gives NOT(A OR B), 10 gives A XOR B, 11 gives NOT(A XOR B), 12 gives A AND B, 13 gives A AND NOT B, 14 gives NOT(A AND B) and 15 gives NOT A AND B. cond_o is 0 for these codes.
- R5: The shift amount is B[4:0], and the other bits of B are ignored. Code 16 is a logical right shift, 17 a left shift, 18 an arithmetic right shift and 19 a left rotate. cond_o is 0 for these codes.
- R6: Codes 24 to 31, except 26, set cond_o as follows: 24 when A equals B, 25 on the carry out of the unsigned sum A+B, 27 on signed overflow of A+B, 28 when A is less than B (signed), 29 when A is at most B (signed), 30 when A is less than B (unsigned), 31 when A is at most B (unsigned). For these codes result_o is the condition in bit 0 with all other bits zero.
- R7: Code 26 returns the signed minimum of A and B, and sets cond_o when A is less than B (signed).
- R8: Code 20 (signed) and code 22 (unsigned) return the low 32 bits of the product A*B. cond_o is set when the full 64-bit product is not representable in 32 bits of the same signedness.
- R9: Code 21 (signed) and code 23 (unsigned) return the quotient A/B, truncated toward zero and taken modulo 2^32, with cond_o 0 when B is nonzero.
- R10: For codes 21 and 23 with B equal to zero, the result is all ones and cond_o is 1.
- R11: For codes other than 20 to 23, done_o is high in the cycle right after the start cycle. For codes 20 to 23 it is high 33 cycles after the start cycle. done_o is high for one cycle per operation.
- R12: A start strobe that arrives while a code 20 to 23 operation is running is ignored. Operands that change after the start edge do not affect the result, and result_o and cond_o hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that launches an operation |
| op_i | input | 5 | Operation code, sampled with start_i |
| a_i | input | 32 | First operand, sampled with start_i |
| b_i | input | 32 | Second operand, sampled with start_i |
| result_o | output | 32 | Result of the last completed operation |
| cond_o | output | 1 | Condition bit of the last completed operation |
| done_o | output | 1 | Completion pulse |

## Verification
A corrupted bit in the multiply/divide partial registers cannot be seen while the loop runs. It appears as a wrong result or condition in the single done cycle, 33 cycles after start, and divide-by-zero and signed-overflow operands make such errors most visible. A wrong busy or step count shows up at once as done arriving one or more cycles off the expected latency. It can also show up as an ignored start that is wrongly accepted, which changes the result held after completion. Decode errors in the single-cycle groups appear at the next clock as a wrong result or as a condition bit that fails to clear.

// File: rtl/ue_alu_pkg.sv
// Shared opcode encoding for the microengine execution unit.
// Assumes a fixed 5-bit code space, split into four groups of eight by bits [4:3].
package ue_alu_pkg;

    typedef enum logic [4:0] {
        OP_PASS   = 5'd0,
        OP_INCR   = 5'd1,
        OP_INV    = 5'd2,
        OP_NEGATE = 5'd3,
        OP_ADD    = 5'd4,
        OP_RSV5   = 5'd5,
        OP_RSV6   = 5'd6,
        OP_SUB    = 5'd7,
        OP_OR     = 5'd8,
        OP_NOR    = 5'd9,
        OP_XOR    = 5'd10,
        OP_XNOR   = 5'd11,
        OP_AND    = 5'd12,
        OP_ANDN   = 5'd13,
        OP_NAND   = 5'd14,
        OP_ANDNA  = 5'd15,
        OP_SRL    = 5'd16,
        OP_SLL    = 5'd17,
        OP_SRA    = 5'd18,
        OP_ROL    = 5'd19,
        OP_SMUL   = 5'd20,
        OP_SDIV   = 5'd21,
        OP_UMUL   = 5'd22,
        OP_UDIV   = 5'd23,
        OP_EQ     = 5'd24,
        OP_CARRY  = 5'd25,
        OP_SMIN   = 5'd26,
        OP_SOVF   = 5'd27,
        OP_SLT    = 5'd28,
        OP_SLE    = 5'd29,
        OP_ULT    = 5'd30,
        OP_ULE    = 5'd31
    } alu_op_e;

    // True for the four codes that use the bit-serial multiply/divide loop.
    function automatic logic is_iterative(logic [4:0] op);
        return (op[4:3] == 2'b10) && op[2];
    endfunction

endpackage

// File: rtl/ue_alu_arith.sv
// Single-cycle datapath for the two low groups: moves, add/subtract and
// two-input bitwise functions. Purely combinational; it never sets a condition.
// Assumes the caller selects this output only when op[4] is zero.
module ue_alu_arith
    import ue_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Pick the move, arithmetic or bitwise function named by the code.
    always_comb begin
        res = '0;
        case (op)
            OP_PASS:   res = a;
            OP_INCR:   res = a + ONE;
            OP_INV:    res = ~a;
            OP_NEGATE: res = ~a + ONE;
            OP_ADD:    res = a + b;
            OP_SUB:    res = a - b;
            OP_OR:     res = a | b;
            OP_NOR:    res = ~(a | b);
            OP_XOR:    res = a ^ b;
            OP_XNOR:   res = ~(a ^ b);
            OP_AND:    res = a & b;
            OP_ANDN:   res = a & ~b;
            OP_NAND:   res = ~(a & b);
            OP_ANDNA:  res = ~a & b;
            default:   res = '0;
        endcase
    end

endmodule

// File: rtl/ue_alu_shcmp.sv
// Single-cycle datapath for shifts/rotate and for the comparison group.
// Comparisons share one W-bit adder and one unsigned compare; the signed order
// is derived from the unsigned one and the sign bits.
// Assumes W is a power of two, so the shift amount is B[log2(W)-1:0].
module ue_alu_shcmp
    import ue_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         cond
);

    localparam int SW = $clog2(W);

    logic [SW-1:0]  sh;
    logic [2*W-1:0] dbl;
    logic [W-1:0]   rol;
    logic [W-1:0]   sum_w;
    logic           eq, ult, slt, cry, ovf;

    assign sh    = b[SW-1:0];
    assign dbl   = {a, a} << sh;
    assign rol   = dbl[2*W-1:W];
    assign sum_w = a + b;
    assign eq    = (a == b);
    assign ult   = (a < b);
    assign slt   = (a[W-1] ^ b[W-1]) ? a[W-1] : ult;
    assign cry   = (sum_w < a);
    assign ovf   = (a[W-1] == b[W-1]) && (sum_w[W-1] != a[W-1]);

    // Select shift/rotate output or form the condition, then pack the condition.
    always_comb begin
        res  = '0;
        cond = 1'b0;
        case (op)
            OP_SRL:   res = a >> sh;
            OP_SLL:   res = a << sh;
            OP_SRA:   res = W'($signed(a) >>> sh);
            OP_ROL:   res = rol;
            OP_EQ:    cond = eq;
            OP_CARRY: cond = cry;
            OP_SMIN:  cond = slt;
            OP_SOVF:  cond = ovf;
            OP_SLT:   cond = slt;
            OP_SLE:   cond = slt | eq;
            OP_ULT:   cond = ult;
            OP_ULE:   cond = ult | eq;
            default: begin
                res  = '0;
                cond = 1'b0;
            end
        endcase
        if (op == OP_SMIN)
            res = slt ? a : b;
        else if (op[4:3] == 2'b11)
            res = {{(W-1){1'b0}}, cond};
    end

    // The derived signed order must agree with a direct signed compare (R6).
    always_comb begin
        p_slt_agree_r6: assert (slt == ($signed(a) < $signed(b)))
            else $error("signed order derivation disagrees");
    end

    // A rotate keeps every bit of A, so the population count is unchanged (R5).
    always_comb begin
        p_rot_keeps_bits_r5: assert ($countones(rol) == $countones(a))
            else $error("rotate lost or created bits");
    end

    // The minimum never exceeds either operand (R7).
    always_comb begin
        if (op == OP_SMIN) begin
            p_min_bound_r7: assert (($signed(res) <= $signed(a)) && ($signed(res) <= $signed(b)))
                else $error("minimum exceeds an operand");
        end
    end

endmodule

// File: rtl/ue_alu_muldiv.sv
// Bit-serial multiply (shift-add) and divide (restoring) unit. It retires one
// bit per clock for W clocks after a load. Signed forms run on magnitudes,
// and the sign is applied in the last step. The final value is presented
// combinationally during the last step (last_o) so that the caller registers it.
// Assumes load_i is raised only while busy_o is low.
module ue_alu_muldiv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         div_i,
    input  logic         sgn_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         last_o,
    output logic [W-1:0] res_o,
    output logic         cond_o
);

    localparam int            CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic           busy_q, div_q, sgn_q, neg_q, dz_q;
    logic [CW-1:0]  cnt_q;
    logic [W-1:0]   hi_q, lo_q, opd_q;
    logic [W-1:0]   mag_a, mag_b, addend, hi_n, lo_n, quot;
    logic [W:0]     mul_sum, rem_sh, rem_dif;
    logic [2*W-1:0] prod, sprod;

    assign mag_a = (sgn_i && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
    assign mag_b = (sgn_i && b_i[W-1]) ? (~b_i + 1'b1) : b_i;

    // One iteration: add-and-shift for multiply, trial subtract for divide.
    always_comb begin
        addend  = lo_q[0] ? opd_q : '0;
        mul_sum = {1'b0, hi_q} + {1'b0, addend};
        rem_sh  = {hi_q, lo_q[W-1]};
        rem_dif = rem_sh - {1'b0, opd_q};
        if (div_q) begin
            if (!rem_dif[W]) begin
                hi_n = rem_dif[W-1:0];
                lo_n = {lo_q[W-2:0], 1'b1};
            end else begin
                hi_n = rem_sh[W-1:0];
                lo_n = {lo_q[W-2:0], 1'b0};
            end
        end else begin
            hi_n = mul_sum[W:1];
            lo_n = {mul_sum[0], lo_q[W-1:1]};
        end
    end

    // Apply the sign and form the condition from the state after the last step.
    always_comb begin
        prod  = {hi_n, lo_n};
        sprod = neg_q ? (~prod + 1'b1) : prod;
        quot  = neg_q ? (~lo_n + 1'b1) : lo_n;
        if (div_q) begin
            res_o  = dz_q ? '1 : quot;
            cond_o = dz_q;
        end else begin
            res_o  = sprod[W-1:0];
            cond_o = sgn_q ? (sprod[2*W-1:W] != {W{sprod[W-1]}})
                           : (prod[2*W-1:W] != '0);
        end
    end

    // Load operands on start, then step W times and drop busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            div_q  <= 1'b0;
            sgn_q  <= 1'b0;
            neg_q  <= 1'b0;
            dz_q   <= 1'b0;
            cnt_q  <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            opd_q  <= '0;
        end else if (load_i) begin
            busy_q <= 1'b1;
            div_q  <= div_i;
            sgn_q  <= sgn_i;
            neg_q  <= sgn_i && (a_i[W-1] ^ b_i[W-1]);
            dz_q   <= (b_i == '0);
            cnt_q  <= '0;
            hi_q   <= '0;
            lo_q   <= mag_a;
            opd_q  <= mag_b;
        end else if (busy_q) begin
            hi_q  <= hi_n;
            lo_q  <= lo_n;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST)
                busy_q <= 1'b0;
        end
    end

    assign busy_o = busy_q;
    assign last_o = busy_q && (cnt_q == LAST);

    // Restoring division keeps the partial remainder below the divisor (R9).
    p_rem_below_divisor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && div_q && !dz_q) |-> (hi_q < opd_q));

endmodule

// File: rtl/ue_alu.sv
// Top of the microengine execution unit. It decodes the 5-bit code and routes
// single-cycle groups to the combinational datapaths, and multiply/divide to
// the bit-serial unit. Result, condition and done are registered here.
// Assumes start_i is a one-cycle strobe. Starts during a serial operation are dropped.
module ue_alu
    import ue_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [4:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] result_o,
    output logic         cond_o,
    output logic         done_o
);

    logic [W-1:0] lo_res, hi_res, md_res, imm_res;
    logic         hi_cond, md_cond, imm_cond;
    logic         md_busy, md_last, is_iter, accept;

    assign is_iter  = is_iterative(op_i);
    assign accept   = start_i && !md_busy;
    assign imm_res  = op_i[4] ? hi_res : lo_res;
    assign imm_cond = op_i[4] ? hi_cond : 1'b0;

    ue_alu_arith #(.W(W)) u_arith (
        .op  (op_i),
        .a   (a_i),
        .b   (b_i),
        .res (lo_res)
    );

    ue_alu_shcmp #(.W(W)) u_shcmp (
        .op   (op_i),
        .a    (a_i),
        .b    (b_i),
        .res  (hi_res),
        .cond (hi_cond)
    );

    ue_alu_muldiv #(.W(W)) u_muldiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept && is_iter),
        .div_i  (op_i[0]),
        .sgn_i  (~op_i[1]),
        .a_i    (a_i),
        .b_i    (b_i),
        .busy_o (md_busy),
        .last_o (md_last),
        .res_o  (md_res),
        .cond_o (md_cond)
    );

    // Capture the single-cycle or serial result and raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            cond_o   <= 1'b0;
            done_o   <= 1'b0;
        end else if (accept && !is_iter) begin
            result_o <= imm_res;
            cond_o   <= imm_cond;
            done_o   <= 1'b1;
        end else if (md_last) begin
            result_o <= md_res;
            cond_o   <= md_cond;
            done_o   <= 1'b1;
        end else begin
            done_o   <= 1'b0;
        end
    end

    // An accepted single-cycle start completes on the next cycle (R11).
    p_single_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !md_busy && !is_iter) |=> done_o);

    // No completion can appear while the serial loop is still stepping (R11, R12).
    p_iter_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (md_busy && !md_last) |=> !done_o);

endmodule

// File: tb/tb_ue_alu.sv
`timescale 1ns/1ps
module tb_ue_alu;

    logic        clk = 1'b0;
    logic        rst_n, start_i;
    logic [4:0]  op_i;
    logic [31:0] a_i, b_i, result_o;
    logic        cond_o, done_o;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    ue_alu dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .result_o(result_o), .cond_o(cond_o), .done_o(done_o)
    );

    function automatic logic exp_cond(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
        longint      sp;
        logic [63:0] up;
        logic [32:0] t;
        logic [31:0] s;
        t  = {1'b0, a} + {1'b0, b};
        s  = a + b;
        sp = longint'($signed(a)) * longint'($signed(b));
        up = {32'b0, a} * {32'b0, b};
        case (op)
            5'd20: return sp != longint'($signed(sp[31:0]));
            5'd22: return up[63:32] != 32'b0;
            5'd21, 5'd23: return b == 32'b0;
            5'd24: return a == b;
            5'd25: return t[32];
            5'd26, 5'd28: return $signed(a) < $signed(b);
            5'd27: return (a[31] == b[31]) && (s[31] != a[31]);
            5'd29: return $signed(a) <= $signed(b);
            5'd30: return a < b;
            5'd31: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_res(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
        longint      sp;
        logic [4:0]  s;
        s = b[4:0];
        case (op)
            5'd0:  return a;
            5'd1:  return a + 32'd1;
            5'd2:  return ~a;
            5'd3:  return 32'd0 - a;
            5'd4:  return a + b;
            5'd7:  return a - b;
            5'd8:  return a | b;
            5'd9:  return ~(a | b);
            5'd10: return a ^ b;
            5'd11: return ~(a ^ b);
            5'd12: return a & b;
            5'd13: return a & ~b;
            5'd14: return ~(a & b);
            5'd15: return ~a & b;
            5'd16: return a >> s;
            5'd17: return a << s;
            5'd18: return $signed(a) >>> s;
            5'd19: return (s == 5'd0) ? a : ((a << s) | (a >> (6'd32 - {1'b0, s})));
            5'd20, 5'd22: return a * b;
            5'd21: begin
                if (b == 32'b0) return 32'hFFFF_FFFF;
                sp = longint'($signed(a)) / longint'($signed(b));
                return sp[31:0];
            end
            5'd23: return (b == 32'b0) ? 32'hFFFF_FFFF : a / b;
            5'd26: return ($signed(a) < $signed(b)) ? a : b;
            5'd24, 5'd25, 5'd27, 5'd28, 5'd29, 5'd30, 5'd31:
                return {31'b0, exp_cond(op, a, b)};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_tag(input logic [4:0] op, input logic [31:0] b);
        if (op == 5'd5 || op == 5'd6) return "R3";
        if (op < 5'd8) return "R2";
        if (op < 5'd16) return "R4";
        if (op < 5'd20) return "R5";
        if (op == 5'd20 || op == 5'd22) return "R8";
        if (op == 5'd21 || op == 5'd23) return (b == 32'b0) ? "R10" : "R9";
        if (op == 5'd26) return "R7";
        return "R6";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Launch one operation, wait for done, check latency, value, condition and pulse width.
    task automatic run_op(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
        int          n;
        int          lat;
        logic [31:0] er;
        logic        ec;
        string       tag;
        er  = exp_res(op, a, b);
        ec  = exp_cond(op, a, b);
        tag = req_tag(op, b);
        lat = (op >= 5'd20 && op <= 5'd23) ? 33 : 1;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        a_i = $urandom; b_i = $urandom;
        n = 1;
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(n == lat, "R11", $sformatf("latency op=%0d", op), n, lat);
        chk(result_o == er, tag, $sformatf("result op=%0d a=%h b=%h", op, a, b), result_o, er);
        chk(cond_o == ec, tag, $sformatf("cond op=%0d a=%h b=%h", op, a, b), {31'b0, cond_o}, {31'b0, ec});
        @(negedge clk);
        chk(done_o == 1'b0, "R11", "done pulse width", {31'b0, done_o}, 32'd0);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            5: return $urandom_range(0, 40);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd7411));
        rst_n = 1'b0; start_i = 1'b0; op_i = 5'd0; a_i = 32'd0; b_i = 32'd0;
        repeat (4) @(negedge clk);
        chk(done_o == 1'b0, "R1", "done in reset", {31'b0, done_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(result_o == 32'd0, "R1", "result after reset", result_o, 32'd0);
        chk(cond_o == 1'b0, "R1", "cond after reset", {31'b0, cond_o}, 32'd0);
        chk(done_o == 1'b0, "R1", "done after reset", {31'b0, done_o}, 32'd0);

        // R2 moves and arithmetic
        run_op(5'd0, 32'hDEAD_BEEF, 32'h1);
        run_op(5'd1, 32'hFFFF_FFFF, 32'h0);
        run_op(5'd2, 32'h0F0F_0000, 32'h0);
        run_op(5'd3, 32'h8000_0000, 32'h0);
        run_op(5'd4, 32'hFFFF_FFFF, 32'h2);
        run_op(5'd7, 32'h0, 32'h1);
        // R3 reserved codes clear a condition left set by a compare
        run_op(5'd24, 32'h5, 32'h5);
        run_op(5'd5, 32'hFFFF_FFFF, 32'h1234);
        run_op(5'd31, 32'h1, 32'h1);
        run_op(5'd6, 32'hAAAA_5555, 32'hFFFF_FFFF);
        // R4 complemented logic
        run_op(5'd13, 32'hFF00_FF00, 32'hF0F0_F0F0);
        run_op(5'd15, 32'hFF00_FF00, 32'hF0F0_F0F0);
        run_op(5'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(5'd11, 32'h1234_5678, 32'h1234_5678);
        // R5 shift amount uses B[4:0] only
        run_op(5'd19, 32'h8000_0001, 32'h0000_0020);
        run_op(5'd19, 32'h8000_0001, 32'hFFFF_FFFF);
        run_op(5'd18, 32'h8000_0000, 32'h0000_003F);
        run_op(5'd16, 32'h8000_0000, 32'h0000_0021);
        // R6 and R7 compare corners
        run_op(5'd25, 32'hFFFF_FFFF, 32'h1);
        run_op(5'd27, 32'h7FFF_FFFF, 32'h1);
        run_op(5'd28, 32'h8000_0000, 32'h7FFF_FFFF);
        run_op(5'd30, 32'h8000_0000, 32'h7FFF_FFFF);
        run_op(5'd26, 32'hFFFF_FFFF, 32'h1);
        run_op(5'd26, 32'h3, 32'h3);
        // R8 multiply fit/overflow corners
        run_op(5'd20, 32'h8000_0000, 32'h1);
        run_op(5'd20, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op(5'd22, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(5'd22, 32'h0001_0000, 32'h0000_FFFF);
        // R9 and R10 divide corners
        run_op(5'd21, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op(5'd21, 32'hFFFF_FFF9, 32'h2);
        run_op(5'd23, 32'hFFFF_FFFF, 32'h3);
        run_op(5'd21, 32'h1234, 32'h0);
        run_op(5'd23, 32'h0, 32'h0);

        // R12: a start during a divide is dropped; outputs then hold
        @(negedge clk);
        op_i = 5'd21; a_i = 32'd100; b_i = 32'd7; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; n = 1;
        repeat (2) begin @(negedge clk); n++; end
        op_i = 5'd4; a_i = 32'd1; b_i = 32'd2; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; n++;
        while (!done_o && n < 40) begin @(negedge clk); n++; end
        chk(n == 33, "R12", "latency with dropped start", n, 33);
        chk(result_o == 32'd14, "R12", "quotient with dropped start", result_o, 32'd14);
        repeat (5) @(negedge clk);
        chk(done_o == 1'b0, "R12", "no late completion", {31'b0, done_o}, 32'd0);
        chk(result_o == 32'd14, "R12", "result holds", result_o, 32'd14);

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [4:0] op;
            op = 5'($urandom_range(0, 31));
            run_op(op, pick(), pick());
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule